// File: doc/BRIEF.md
# Pipelined Variable-Latency Read Slave

This block is a memory-mapped target that holds a small register array. A write is taken in a single cycle. A read is taken in a single cycle as well, but its data comes back later and is marked by a one-cycle valid strobe. Several reads can be in flight at the same time. The block stores each accepted read in a short queue of pending responses. Every queue entry waits for a delay drawn from a free-running shift-register sequence, so the interconnect and the master above it see read latencies that vary.

Responses leave the queue in the order their reads were accepted. The value returned is the array content at the moment the read was accepted. Back-pressure is a single stall line. It is high while reset is applied, and it is high when a read is presented while the pending queue is full. The master keeps its request steady for as long as the stall line is high.

Top module: `pipe_rd_slave`

## Requirements
- R1: While `rst` is high, `wait_req` is high and `rd_valid` is low. In the first cycle after reset is released, `rd_valid` stays low.
- R2: When the block is idle after reset and no read is pending, `wait_req` is low.
- R3: A write is accepted in the cycle where `wr` is high and `wait_req` is low. A read accepted in any later cycle at that address returns the written value, including a read in the very next cycle.
- R4: Each accepted read produces exactly one `rd_valid` pulse of one cycle. `rd_data` is valid in that same cycle, and the pulses come in the order the reads were accepted.
- R5: `rd_valid` is never high in the acceptance cycle of its read. A read accepted while no other read is pending returns between 1 and 4 clock edges after the edge that accepted it.
- R6: When 4 reads are pending, a presented read sees `wait_req` high and is not accepted. When fewer than 4 are pending, a presented read sees `wait_req` low. A continuous run of reads reaches the full condition.
- R7: The returned data is the array content at acceptance time. A write to the same address accepted after the read does not change that read's data.
- R8: Across a series of isolated reads, the latency takes at least two different values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address of the request |
| rd | input | 1 | Read request |
| wr | input | 1 | Write request |
| wr_data | input | DATA_W | Write data |
| wait_req | output | 1 | Stall: the request is not taken this cycle |
| rd_data | output | DATA_W | Read response data |
| rd_valid | output | 1 | One-cycle strobe marking a read response |

## Verification
Suppose a queue pointer or occupancy count goes wrong. The scoreboard then sees a response with the wrong data or out of order, a strobe with nothing pending, or a missing strobe, and this shows up no more than a few cycles after the response was due. A broken stall condition shows up at once: in the same cycle, the stall line disagrees with the pending count that the bench keeps for itself. A broken delay counter shows up as a latency outside 1 to 4 on an isolated read, or as a latency that never changes.

// File: rtl/prs_pkg.sv
package prs_pkg;
  localparam int LFSR_W = 8;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 8'h5A;

  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction
endpackage

// File: rtl/prs_regfile.sv
module prs_regfile #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/prs_lat_gen.sv
module prs_lat_gen
  import prs_pkg::*;
#(
  parameter int LAT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [LAT_W-1:0] lat_m1
);
  logic [LFSR_W-1:0] state;

  always_ff @(posedge clk) begin
    if (rst)      state <= LFSR_SEED;
    else if (adv) state <= lfsr_step(state);
  end

  assign lat_m1 = state[LAT_W-1:0];

  // R8: a zero state would lock the sequence and freeze the latency
  a_r8_lfsr_live: assert property (@(posedge clk) disable iff (rst) state != '0)
    else $error("a_r8_lfsr_live");
endmodule

// File: rtl/prs_resp_queue.sv
module prs_resp_queue #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic [CNT_W-1:0]  push_cnt,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] dmem [DEPTH];
  logic [CNT_W-1:0]  cnt  [DEPTH];
  logic [DEPTH-1:0]  vld;
  logic [PW-1:0]     wp, rp;
  logic [PW:0]       count;
  logic              pop;

  assign full = (count == DEPTH[PW:0]);
  assign pop  = vld[rp] && (cnt[rp] == '0);

  always_ff @(posedge clk) begin
    if (push) dmem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp        <= '0;
      rp        <= '0;
      count     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= pop;
      if (pop) begin
        out_data <= dmem[rp];
        rp       <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      end
      if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        vld[i] <= 1'b0;
        cnt[i] <= '0;
      end else if (push && wp == PW'(i)) begin
        vld[i] <= 1'b1;
        cnt[i] <= push_cnt;
      end else if (pop && rp == PW'(i)) begin
        vld[i] <= 1'b0;
      end else if (vld[i] && cnt[i] != '0) begin
        cnt[i] <= cnt[i] - 1'b1;
      end
    end
  end

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    count <= DEPTH[PW:0]) else $error("a_r6_no_overflow");

  a_r6_no_push_full: assert property (@(posedge clk) disable iff (rst)
    full |-> !push) else $error("a_r6_no_push_full");

  a_r5_min_latency: assert property (@(posedge clk) disable iff (rst)
    (count == '0 && !push) |=> !out_valid) else $error("a_r5_min_latency");

  a_r4_pop_pending: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(count) != '0) else $error("a_r4_pop_pending");
endmodule

// File: rtl/pipe_rd_slave.sv
module pipe_rd_slave #(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int Q_DEPTH = 4,
  parameter int LAT_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wait_req,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  logic              q_full;
  logic              acc_rd, acc_wr;
  logic [DATA_W-1:0] arr_q;
  logic [LAT_W-1:0]  lat_m1;

  assign wait_req = rst | (rd & q_full);
  assign acc_rd   = rd & ~wait_req;
  assign acc_wr   = wr & ~wait_req;

  prs_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .we(acc_wr), .waddr(addr), .wdata(wr_data),
    .raddr(addr), .rdata(arr_q)
  );

  prs_lat_gen #(.LAT_W(LAT_W)) u_lat (
    .clk(clk), .rst(rst), .adv(acc_rd), .lat_m1(lat_m1)
  );

  prs_resp_queue #(.DATA_W(DATA_W), .DEPTH(Q_DEPTH), .CNT_W(LAT_W)) u_q (
    .clk(clk), .rst(rst), .push(acc_rd), .push_data(arr_q), .push_cnt(lat_m1),
    .out_data(rd_data), .out_valid(rd_valid), .full(q_full)
  );

  // R1: no response strobe right after reset is released
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $past(rst) |-> !rd_valid) else $error("a_r1_quiet_after_reset");
endmodule

// File: tb/tb_pipe_rd_slave.sv
module tb_pipe_rd_slave;
  localparam int AW = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          rd = 1'b0, wr = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          wait_req;
  logic [DW-1:0] rd_data;
  logic          rd_valid;

  pipe_rd_slave dut (.*);

  always #2 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;
  bit done = 0, saw_full = 0;
  bit [4:0] lat_seen = '0;
  logic [DW-1:0] model [16];
  logic [DW-1:0] exp_data[$];
  int            exp_acc[$];
  bit            exp_iso[$];
  string         exp_req[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_data.size() == 0) begin
        chk(0, "R4", "strobe with nothing pending", 32'd1, 32'd0);
      end else begin
        automatic logic [DW-1:0] e = exp_data.pop_front();
        automatic int lat = cyc - exp_acc.pop_front() - 1;
        automatic bit iso = exp_iso.pop_front();
        automatic string rq = exp_req.pop_front();
        chk(rd_data === e, rq, "response data/order", rd_data, e);
        chk(lat >= 1, "R5", "latency at least one", lat, 1);
        if (iso) begin
          chk(lat >= 1 && lat <= 4, "R5", "isolated latency 1..4", lat, 4);
          if (lat >= 1 && lat <= 4) lat_seen[lat] = 1'b1;
        end
      end
    end
  end

  task automatic do_write(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    rd = 0; wr = 1; addr = a; wr_data = d;
    forever begin
      #1;
      if (!wait_req) break;
      @(negedge clk);
    end
    model[a] = d;
    @(posedge clk);
  endtask

  task automatic do_read(logic [AW-1:0] a, string rq);
    @(negedge clk);
    wr = 0; rd = 1; addr = a;
    forever begin
      #1;
      // R6: stall line must track the pending count
      chk(wait_req == (exp_data.size() == 4), "R6", "stall vs pending count",
          wait_req, exp_data.size() == 4);
      if (exp_data.size() == 4) saw_full = 1;
      if (!wait_req) break;
      @(negedge clk);
    end
    exp_iso.push_back(exp_data.size() == 0);
    exp_data.push_back(model[a]);
    exp_acc.push_back(cyc);
    exp_req.push_back(rq);
    @(posedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      rd = 0; wr = 0;
    end
  endtask

  task automatic drain();
    int guard = 0;
    idle(1);
    while (exp_data.size() != 0 && guard < 100) begin
      @(negedge clk); guard++;
    end
    chk(exp_data.size() == 0, "R4", "all responses returned", exp_data.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "R4", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(wait_req === 1'b1, "R1", "stall during reset", wait_req, 1);
    chk(rd_valid === 1'b0, "R1", "no strobe during reset", rd_valid, 0);
    rst = 0;
    @(negedge clk);
    chk(rd_valid === 1'b0, "R1", "no strobe after reset", rd_valid, 0);
    chk(wait_req === 1'b0, "R2", "idle stall low", wait_req, 0);
    idle(2);
    chk(wait_req === 1'b0, "R2", "idle stall still low", wait_req, 0);

    for (int i = 0; i < 16; i++) do_write(AW'(i), 32'hC0DE_0000 + 32'(i * 4099));

    // R5, R8: isolated reads
    for (int i = 0; i < 16; i++) begin
      do_read(AW'(i), "R4");
      drain();
    end

    // R3: write then read the next cycle
    do_write(4'd5, 32'h1234_5678);
    do_read(4'd5, "R3");
    drain();

    // R7: read, then overwrite the same address, then read again
    do_read(4'd7, "R7");
    do_write(4'd7, 32'hDEAD_BEEF);
    do_read(4'd7, "R7");
    drain();

    // R6: continuous reads fill the queue
    for (int i = 0; i < 40; i++) do_read(AW'((i * 3) % 16), "R4");
    drain();
    chk(saw_full, "R6", "queue full reached", saw_full, 1);

    // R8: latency variation among isolated reads
    chk($countones(lat_seen) >= 2, "R8", "distinct latencies", $countones(lat_seen), 2);

    idle(3);
    chk(rd_valid === 1'b0, "R4", "no stray strobe when idle", rd_valid, 0);
    summary();
  end
endmodule